// File: doc/BRIEF.md
# One-Second Decimal Digit Cycler

This block drives one seven-segment display. It shows the decimal digits in rising order, from 0 up to 9, and then starts again at 0. Each digit stays on the display for about one second. There is a single 50 MHz system clock. A prescaler counts clock cycles and raises a one-cycle advance pulse once per interval. That pulse is an enable on the digit register. It is never used as a clock. A combinational encoder turns the current digit into an active-low segment pattern.

The interval length is a parameter, `TICK_PERIOD`, given in clock cycles. Its default is 50,000,000, which is one second at 50 MHz. A bench can set a small value and check the whole digit sequence in a few hundred cycles. There is a synchronous, active-high reset that returns the block to digit 0.

Top module: `digit_cycler`

## Requirements
- R1: On each advance pulse, the digit register moves to the next higher digit, so the display steps 0, 1, 2 and so on up to 9.
- R2: The advance pulse that arrives while the digit is 9 loads 0. The digit never takes a value above 9.
- R3: Each digit stays on the display for exactly `TICK_PERIOD` clock cycles. The default of 50,000,000 cycles equals one second at 50 MHz.
- R4: The advance pulse is high for exactly one cycle. The next pulse comes `TICK_PERIOD` cycles later. The prescaler count stays in the range 0 to `TICK_PERIOD`-1.
- R5: The digit register changes only in cycles where the advance pulse is high. Every flop runs on `clk` alone.
- R6: While `rst` is high at a rising edge, both the prescaler and the digit clear to 0. After `rst` falls, digit 0 is shown for a full `TICK_PERIOD` cycles.
- R7: The segment outputs are active low. Bit 0 drives segment a, and bits 1 to 6 drive segments b to g in that order. Each digit maps to one fixed 7-bit pattern, written below as bit 6 down to bit 0:

| Digit | Pattern |
|---|---|
| 0 | 1000000 |
| 1 | 1111001 |
| 2 | 0100100 |
| 3 | 0110000 |
| 4 | 0011001 |
| 5 | 0010010 |
| 6 | 0000010 |
| 7 | 1111000 |
| 8 | 0000000 |
| 9 | 0011000 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock (50 MHz in use) |
| rst | input | 1 | Synchronous reset, active high |
| seg_n | output | 7 | Active-low segment drive, bit 0 = a through bit 6 = g |

## Verification
The bound checker looks at every cycle. It checks that the digit holds steady except on an advance pulse, and that each pulse either adds one or wraps from 9 to 0. It checks that the pulse lasts one cycle and falls exactly on the interval boundary, which it measures with its own counter. It also checks that reset clears the state and that the display is never fully dark. Only the bench scenarios can show the exact segment pattern for each digit, the hold length from the first cycle after reset, and a restart after a reset in the middle of an interval. The bench shows these by comparing the outputs against a behavioural model on every cycle.

// File: rtl/digcyc_pkg.sv
package digcyc_pkg;
    localparam int SEG_W = 7;
    localparam int DIG_W = 4;
    localparam logic [DIG_W-1:0] LAST_DIGIT = 4'd9;

    typedef logic [DIG_W-1:0] digit_t;
    typedef logic [SEG_W-1:0] seg_t;
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
    parameter int TICK_PERIOD = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;
    localparam logic [CNT_W-1:0] TERM = CNT_W'(TICK_PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == TERM) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt == TERM);
endmodule

// File: rtl/digit_step.sv
module digit_step
    import digcyc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    output digit_t digit
);
    typedef struct packed {
        digit_t dig;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (st_q.dig >= LAST_DIGIT) begin
                st_d.dig = '0;
            end else begin
                st_d.dig = st_q.dig + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign digit = st_q.dig;
endmodule

// File: rtl/seg_enc.sv
module seg_enc
    import digcyc_pkg::*;
(
    input  digit_t digit,
    output seg_t   seg_n
);
    // Active low; bit 0 is segment a, bit 6 is segment g.
    always_comb begin
        unique case (digit)
            4'd0:    seg_n = 7'b1000000;
            4'd1:    seg_n = 7'b1111001;
            4'd2:    seg_n = 7'b0100100;
            4'd3:    seg_n = 7'b0110000;
            4'd4:    seg_n = 7'b0011001;
            4'd5:    seg_n = 7'b0010010;
            4'd6:    seg_n = 7'b0000010;
            4'd7:    seg_n = 7'b1111000;
            4'd8:    seg_n = 7'b0000000;
            4'd9:    seg_n = 7'b0011000;
            default: seg_n = 7'b0111111; // unreachable: dash
        endcase
    end
endmodule

// File: rtl/digit_cycler.sv
module digit_cycler #(
    parameter int TICK_PERIOD = 50_000_000
) (
    input  logic       clk,
    input  logic       rst,
    output logic [6:0] seg_n
);
    import digcyc_pkg::*;

    logic   tick_w;
    digit_t digit_w;

    tick_gen #(.TICK_PERIOD(TICK_PERIOD)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_w)
    );

    digit_step u_step (
        .clk   (clk),
        .rst   (rst),
        .adv   (tick_w),
        .digit (digit_w)
    );

    seg_enc u_enc (
        .digit (digit_w),
        .seg_n (seg_n)
    );
endmodule

// File: rtl/digit_cycler_chk.sv
module digit_cycler_chk #(
    parameter int TICK_PERIOD = 50_000_000
) (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [3:0] digit,
    input logic [6:0] seg_n
);
    // Independent interval counter, so no long $past window is needed.
    int unsigned gap_q;

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            gap_q <= 0;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (tick && digit < 4'd9) |=> digit == $past(digit) + 4'd1);

    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && digit == 4'd9) |=> digit == 4'd0);

    a_r2_range: assert property (@(posedge clk) disable iff (rst)
        digit <= 4'd9);

    a_r4_single_cycle: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    a_r4_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |-> gap_q == TICK_PERIOD - 1);

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(digit));

    a_r6_reset: assert property (@(posedge clk)
        rst |=> (digit == 4'd0));

    a_r7_lit: assert property (@(posedge clk) disable iff (rst)
        seg_n != 7'b1111111);
endmodule

bind digit_cycler digit_cycler_chk #(.TICK_PERIOD(TICK_PERIOD)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_w),
    .digit (digit_w),
    .seg_n (seg_n)
);

// File: tb/test_digit_cycler.sv
module test_digit_cycler;
    localparam int P = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] seg_n;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit done    = 0;

    // reference model state
    int m_cnt = 0;
    int m_dig = 0;
    int m_run = 0;       // cycles the current model digit has been shown
    bit m_in_rst = 1;
    bit m_changed = 0;
    int prev_dig = 0;

    always #5 clk = ~clk;

    digit_cycler #(.TICK_PERIOD(P)) i_digit_cycler (
        .clk   (clk),
        .rst   (rst),
        .seg_n (seg_n)
    );

    // R7: active-low patterns, bit 0 = a ... bit 6 = g
    function automatic logic [6:0] exp_seg(int d);
        case (d)
            0: return 7'b1000000;
            1: return 7'b1111001;
            2: return 7'b0100100;
            3: return 7'b0110000;
            4: return 7'b0011001;
            5: return 7'b0010010;
            6: return 7'b0000010;
            7: return 7'b1111000;
            8: return 7'b0000000;
            default: return 7'b0011000;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        prev_dig = m_dig;
        if (rst) begin
            m_cnt = 0; m_dig = 0; m_in_rst = 1; m_run = 0;
        end else begin
            m_in_rst = 0;
            if (m_cnt == P - 1) begin
                m_cnt = 0;
                m_dig = (m_dig + 1) % 10;
            end else begin
                m_cnt++;
            end
        end
        m_changed = (m_dig != prev_dig) && !m_in_rst;
        if (m_changed) m_run = 0; else if (!m_in_rst) m_run++;
    end

    task automatic check(string req, logic [6:0] act, logic [6:0] expv);
        vectors++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: seg_n=%b expected %b (model digit %0d)", req, act, expv, m_dig);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!done && cycles > 0) begin
            if (m_in_rst)
                check("R6 reset", seg_n, exp_seg(0));
            else if (m_changed && m_dig == 0)
                check("R2 wrap", seg_n, exp_seg(m_dig));
            else if (m_changed)
                check("R1 step", seg_n, exp_seg(m_dig));
            else if (m_run < P)
                check("R3/R5 hold", seg_n, exp_seg(m_dig));
            else
                check("R3 run length", seg_n, exp_seg(m_dig));
        end
    end

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // measure hold length of one digit at the ports (R3)
    task automatic measure_hold(logic [6:0] pat);
        int len = 0;
        while (seg_n !== pat) @(negedge clk);
        while (seg_n === pat && len < 4 * P) begin
            len++;
            @(negedge clk);
        end
        vectors++;
        if (len != P) begin
            fails++;
            $display("FAIL R3: hold length %0d expected %0d", len, P);
        end
    endtask

    initial begin
        wait_cycles(3);
        check("R6 reset state", seg_n, 7'b1000000);
        rst = 1'b0;
        // R6: digit 0 shown for full interval after reset release
        begin
            int len = 0;
            while (seg_n === 7'b1000000 && len < 4 * P) begin
                len++;
                @(negedge clk);
            end
            vectors++;
            if (len != P) begin
                fails++;
                $display("FAIL R6: post-reset hold %0d expected %0d", len, P);
            end
        end
        // R1/R7: digit 1 follows
        check("R1 first step", seg_n, 7'b1111001);
        measure_hold(7'b0100100);   // digit 2
        measure_hold(7'b0000000);   // digit 8
        // R2: after 9 comes 0
        while (seg_n !== 7'b0011000) @(negedge clk);
        wait_cycles(P);
        check("R2 wrap to zero", seg_n, 7'b1000000);
        wait_cycles(12 * P);        // second full lap, per-cycle compares
        // R6: mid-interval reset
        wait_cycles(2);
        rst = 1'b1;
        wait_cycles(2);
        check("R6 mid-run reset", seg_n, 7'b1000000);
        rst = 1'b0;
        wait_cycles(P - 1);
        check("R6 still zero", seg_n, 7'b1000000);
        wait_cycles(1);
        check("R1 step after reset", seg_n, 7'b1111001);
        wait_cycles(25 * P);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        wait (cycles > 5000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected <=5000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule